// File: doc/BRIEF.md
# Serial Converter Word Loader with Daisy-Chain Output

This block is the digital front end of a 12-bit serial-input converter. A serial bit stream is shifted, most significant bit first, into a 12-bit input register. Four asynchronous strobe pins can clock the shift. Three of them act on a rising edge and one acts on a falling edge. The bit leaving the top of the input register drives a serial output, so several loaders can be wired in a chain and share one data line. A separate 12-bit converter code register drives the parallel output. It takes the input register contents only while two active-low load pins are both low. An asynchronous active-low clear forces that code register to zero.

The strobes, the serial data pin and the load pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer. The strobes are then merged into one activity level, and the edges of that level are detected on the system clock. The design therefore needs no clock other than the system clock.

Top module: `sdac_loader`

## Requirements
- R1: While `rst_n` is low, the input register and the code register are zero, so `dac_code` is 0 and `ser_out` is 0.
- R2: The merged strobe level is `strb_a | strb_b | ~strb_c_n | strb_d`. Each rising edge of this level shifts the input register by exactly one bit. The shift takes effect at the third system-clock rising edge, counting the first edge that sees the new pin levels.
- R3: On a shift, the register moves toward its MSB (bit 11). The bit on `ser_in` enters at bit 0. `ser_in` is taken from the same edge sample as the strobe levels. `ser_out` always shows bit 11, so words enter and leave MSB first.
- R4: The value on `ser_out` just before any shift equals the `ser_in` bit accepted 12 shifts earlier, or 0 if fewer than 12 shifts have occurred since reset. A previously loaded word therefore appears on `ser_out` MSB first while the next word is shifted in.
- R5: While any one strobe is held at its active level (`strb_a`, `strb_b` or `strb_d` high, or `strb_c_n` low), toggling the other strobes shifts nothing. Releasing the held strobe also shifts nothing.
- R6: The code register copies the input register one system-clock edge after the synchronized loads are both low. The loads reach that point two edges after the pins change. If only one load pin is low, the code register keeps its value.
- R7: While both load pins stay low, the code register follows the input register, so each shift shows up on `dac_code` one clock later.
- R8: While `clear_n` is low, `dac_code` is 0 at once, with no clock edge needed, whatever the load pins do. After `clear_n` rises, the code register stays 0 until the next transfer.
- R9: `clear_n` does not change the input register. Its contents and its shifting are unaffected, and a later transfer delivers them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample all pins |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| strb_a | input | 1 | Shift strobe, active on a rising edge |
| strb_b | input | 1 | Shift strobe, active on a rising edge |
| strb_c_n | input | 1 | Shift strobe, active on a falling edge |
| strb_d | input | 1 | Shift strobe, active on a rising edge |
| ser_in | input | 1 | Serial data input, MSB first |
| ld_a_n | input | 1 | Active-low load enable, first of two |
| ld_b_n | input | 1 | Active-low load enable, second of two |
| clear_n | input | 1 | Asynchronous active-low clear of the code register |
| ser_out | output | 1 | Serial output for chaining, bit 11 of the input register |
| dac_code | output | 12 | Converter code register |

## Verification
The hardest state to reach from the ports is a second strobe edge that arrives while another strobe already holds the merged level active. The bench gets there by raising `strb_d`, which gives one intended shift, and then pulsing `strb_a` several times with changing `ser_in` before releasing `strb_d`. A transfer afterwards shows that the register moved by exactly one bit. Asynchronous clear is driven between clock edges and checked before the next edge. The bench then shifts while clear is held and finishes with a late transfer, which shows that the input register came through untouched.

// File: rtl/sdl_pkg.sv
package sdl_pkg;
  localparam int unsigned SDL_WORD_W      = 12;
  localparam int unsigned SDL_STRB_N      = 4;
  localparam logic [3:0]  SDL_STRB_ACTLOW = 4'b0100;  // strobe index 2 acts on its falling edge
  localparam int unsigned SDL_SYNC_STAGES = 2;
endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int unsigned W       = 1,
  parameter logic [W-1:0] RST_VAL = '0,
  parameter int unsigned STAGES  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] stg_d;
      if (g == 0) begin : g_first
        assign stg_d = d;
      end else begin : g_next
        assign stg_d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/sdl_strobe_merge.sv
module sdl_strobe_merge #(
  parameter int unsigned   N        = 4,
  parameter logic [N-1:0]  ACT_LOW  = '0,
  parameter int unsigned   STAGES   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strb,
  output logic         shift_pulse
);
  logic [N-1:0] strb_sync;
  logic [N-1:0] strb_act;
  logic         any_act;
  logic         any_prev_q;
  logic         any_prev_d;

  // reset value of each synchronizer bit is that strobe's idle level
  sdl_sync #(.W(N), .RST_VAL(ACT_LOW), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(strb), .q(strb_sync)
  );

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_pol
      if (ACT_LOW[g]) begin : g_low
        assign strb_act[g] = ~strb_sync[g];
      end else begin : g_high
        assign strb_act[g] = strb_sync[g];
      end
    end
  endgenerate

  assign any_act     = |strb_act;
  assign any_prev_d  = any_act;
  assign shift_pulse = any_act & ~any_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) any_prev_q <= 1'b0;
    else        any_prev_q <= any_prev_d;
  end
endmodule

// File: rtl/sdl_shift_reg.sv
module sdl_shift_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] word_q
);
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end
endmodule

// File: rtl/sdl_hold_reg.sv
module sdl_hold_reg #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         load_en,
  input  logic [W-1:0] word,
  output logic [W-1:0] code_q
);
  logic [W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (load_en) code_d = word;
  end

  always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
    if (!rst_n)      code_q <= '0;
    else if (!clr_n) code_q <= '0;
    else             code_q <= code_d;
  end
endmodule

// File: rtl/sdac_loader.sv
module sdac_loader #(
  parameter int unsigned WORD_W      = sdl_pkg::SDL_WORD_W,
  parameter int unsigned SYNC_STAGES = sdl_pkg::SDL_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic              strb_c_n,
  input  logic              strb_d,
  input  logic              ser_in,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  input  logic              clear_n,
  output logic              ser_out,
  output logic [WORD_W-1:0] dac_code
);
  localparam int unsigned STRB_N = sdl_pkg::SDL_STRB_N;

  logic [STRB_N-1:0] strb_vec;
  logic              shift_pulse;
  logic              sdi_sync;
  logic [1:0]        ld_sync_n;
  logic              load_both;
  logic [WORD_W-1:0] in_word;

  assign strb_vec = {strb_d, strb_c_n, strb_b, strb_a};

  sdl_strobe_merge #(
    .N(STRB_N), .ACT_LOW(sdl_pkg::SDL_STRB_ACTLOW), .STAGES(SYNC_STAGES)
  ) u_strb (
    .clk(clk), .rst_n(rst_n), .strb(strb_vec), .shift_pulse(shift_pulse)
  );

  sdl_sync #(.W(1), .RST_VAL(1'b0), .STAGES(SYNC_STAGES)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .d(ser_in), .q(sdi_sync)
  );

  sdl_sync #(.W(2), .RST_VAL(2'b11), .STAGES(SYNC_STAGES)) u_ld_sync (
    .clk(clk), .rst_n(rst_n), .d({ld_b_n, ld_a_n}), .q(ld_sync_n)
  );

  assign load_both = ~ld_sync_n[0] & ~ld_sync_n[1];

  sdl_shift_reg #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_pulse), .din(sdi_sync), .word_q(in_word)
  );

  sdl_hold_reg #(.W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr_n(clear_n), .load_en(load_both),
    .word(in_word), .code_q(dac_code)
  );

  assign ser_out = in_word[WORD_W-1];
endmodule

// File: rtl/sdac_loader_chk.sv
module sdac_loader_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clear_n,
  input logic         shift_pulse,
  input logic         sdi_sync,
  input logic         load_both,
  input logic [W-1:0] in_word,
  input logic [W-1:0] dac_code
);
  // R8: code register reads zero whenever clear is low at an edge
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> dac_code == '0);

  // R5, R9: input register moves only on a detected strobe edge
  a_r5_no_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_pulse |=> $stable(in_word));

  // R3: new bit enters at bit 0, old bits move toward the MSB
  a_r3_lsb_entry: assert property (@(posedge clk) disable iff (!rst_n)
    shift_pulse |=> (in_word[0] == $past(sdi_sync)) &&
                    (in_word[W-1:1] == $past(in_word[W-2:0])));

  // R6, R7: transfer copies the input register
  a_r6_transfer: assert property (@(posedge clk) disable iff (!rst_n)
    load_both |=> (!clear_n || dac_code == $past(in_word)));

  // R6: no transfer keeps the code
  a_r6_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_both && clear_n) |=> (!clear_n || $stable(dac_code)));
endmodule

bind sdac_loader sdac_loader_chk #(.W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_n(clear_n), .shift_pulse(shift_pulse),
  .sdi_sync(sdi_sync), .load_both(load_both), .in_word(in_word), .dac_code(dac_code)
);

// File: tb/sdac_loader_tb.sv
`timescale 1ns/1ps
module sdac_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        strb_a, strb_b, strb_c_n, strb_d;
  logic        ser_in, ld_a_n, ld_b_n, clear_n;
  logic        ser_out;
  logic [11:0] dac_code;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R1";
  bit    done     = 0;

  // behavioural reference: sample history (index 0 newest) and two words
  bit          h_strb[$];
  bit          h_sdi[$];
  bit          h_ld[$];
  logic [11:0] m_in;
  logic [11:0] m_dac;

  sdac_loader u_dut (
    .clk(clk), .rst_n(rst_n), .strb_a(strb_a), .strb_b(strb_b), .strb_c_n(strb_c_n),
    .strb_d(strb_d), .ser_in(ser_in), .ld_a_n(ld_a_n), .ld_b_n(ld_b_n),
    .clear_n(clear_n), .ser_out(ser_out), .dac_code(dac_code)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit sh;
    bit dbit;
    bit lb;
    @(posedge clk);
    sh   = h_strb[1] && !h_strb[2];
    dbit = h_sdi[1];
    lb   = h_ld[1];
    if (!clear_n) m_dac = '0;
    else if (lb)  m_dac = m_in;
    if (sh) m_in = {m_in[10:0], dbit};
    h_strb.push_front(strb_a | strb_b | !strb_c_n | strb_d);
    h_sdi.push_front(ser_in);
    h_ld.push_front(!ld_a_n && !ld_b_n);
    void'(h_strb.pop_back());
    void'(h_sdi.pop_back());
    void'(h_ld.pop_back());
    #1;
    check(dac_code === m_dac, cur_req, dac_code, m_dac);
    check(ser_out === m_in[11], cur_req, {11'd0, ser_out}, {11'd0, m_in[11]});
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_strb(input int which, input bit act);
    case (which)
      0: strb_a   = act;
      1: strb_b   = act;
      2: strb_c_n = !act;
      default: strb_d = act;
    endcase
  endtask

  task automatic shift_bit(input int which, input bit b);
    ser_in = b;
    set_strb(which, 1'b1);
    ticks(3);
    set_strb(which, 1'b0);
    ticks(3);
  endtask

  task automatic shift_word(input int which, input logic [11:0] w);
    for (int i = 11; i >= 0; i--) shift_bit(which, w[i]);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=%h expected=%h", 12'h0, 12'h1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] wa, wb, wc, wx;
    logic [11:0] seen;
    wa = 12'hA5C;
    wb = 12'h3B6;
    rst_n = 1'b0;
    strb_a = 0; strb_b = 0; strb_c_n = 1; strb_d = 0;
    ser_in = 0; ld_a_n = 1; ld_b_n = 1; clear_n = 1;
    for (int i = 0; i < 3; i++) begin
      h_strb.push_back(0); h_sdi.push_back(0); h_ld.push_back(0);
    end
    m_in = '0; m_dac = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(dac_code === 12'h000, "R1", dac_code, 12'h000);
    check(ser_out === 1'b0, "R1", {11'd0, ser_out}, 12'h000);
    rst_n = 1'b1;
    ticks(2);

    // R2 R3: word through a rising strobe, loads idle
    cur_req = "R2";
    ser_in = 1'b1;
    strb_a = 1'b1;
    ticks(2);
    check(ser_out === 1'b0 && dac_code === 12'h000, "R2", {11'd0, ser_out}, 12'h000);
    ticks(1);
    strb_a = 1'b0;
    ticks(3);
    cur_req = "R3";
    shift_word(0, wa[10:0] << 1);  // 12 more shifts leave wa-like content; rebuild cleanly below
    shift_word(0, wa);
    check(dac_code === 12'h000, "R6", dac_code, 12'h000);

    // R6 transfer with both loads low
    cur_req = "R6";
    ld_a_n = 0; ld_b_n = 0;
    ticks(4);
    check(dac_code === wa, "R6", dac_code, wa);
    ld_a_n = 1; ld_b_n = 1;
    ticks(3);

    // R4 chain output while wb enters on the falling-edge strobe, one load low only
    cur_req = "R4";
    ld_a_n = 0;
    for (int i = 11; i >= 0; i--) begin
      seen[i] = ser_out;
      shift_bit(2, wb[i]);
    end
    check(seen === wa, "R4", seen, wa);
    check(dac_code === wa, "R6", dac_code, wa);
    ld_a_n = 1;
    ticks(3);
    ld_a_n = 0; ld_b_n = 0;
    ticks(4);
    check(dac_code === wb, "R2", dac_code, wb);
    ld_a_n = 1; ld_b_n = 1;
    ticks(3);

    // R5 held strobe blocks further shifts
    cur_req = "R5";
    ser_in = 1'b1;
    strb_d = 1'b1;
    ticks(4);
    for (int k = 0; k < 4; k++) begin
      ser_in = k[0];
      strb_a = 1'b1; ticks(3);
      strb_a = 1'b0; ticks(3);
    end
    strb_d = 1'b0;
    ticks(4);
    wx = {wb[10:0], 1'b1};
    ld_a_n = 0; ld_b_n = 0;
    ticks(4);
    check(dac_code === wx, "R5", dac_code, wx);

    // R7 code follows while loads stay low
    cur_req = "R7";
    shift_bit(1, 1'b1);
    shift_bit(1, 1'b0);
    shift_bit(3, 1'b1);
    wc = {wx[8:0], 3'b101};
    check(dac_code === wc, "R7", dac_code, wc);

    // R8 asynchronous clear overrides the loads
    cur_req = "R8";
    clear_n = 1'b0;
    #1;
    check(dac_code === 12'h000, "R8", dac_code, 12'h000);
    ticks(2);
    cur_req = "R9";
    shift_bit(0, 1'b0);
    check(dac_code === 12'h000, "R8", dac_code, 12'h000);
    ld_a_n = 1; ld_b_n = 1;
    ticks(3);
    clear_n = 1'b1;
    ticks(4);
    check(dac_code === 12'h000, "R8", dac_code, 12'h000);
    ld_a_n = 0; ld_b_n = 0;
    ticks(4);
    check(dac_code === {wc[10:0], 1'b0}, "R9", dac_code, {wc[10:0], 1'b0});
    ld_a_n = 1; ld_b_n = 1;
    ticks(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule